// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits between a per-warp instruction fetch stage and a narrow array of scalar execution lanes. Fetch deposits the next instruction of a warp into that warp's holding register and marks the warp pending. Each issue slot, the scheduler picks one pending warp whose instruction can safely read and write its registers, and streams that one instruction over the lanes. A full warp of threads is wider than the lane array, so the dispatch takes several consecutive beats, each carrying one lane group, with the warp ID and instruction held steady across all of them.

Readiness comes from an internal per-warp register scoreboard. Issuing an instruction marks its destination busy. A later writeback pulse, carrying a warp ID and a register index, marks it free again. Among the ready warps, the one that has waited longest since it last issued wins, and the lowest warp ID breaks ties. The next selection happens during the last beat of the current dispatch, so successive warps follow each other with no gap. When nothing is ready, the dispatch strobe stays low and the choice is made again in the next cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: `rst_n` is asynchronous and active low, and its release is synchronised inside the block. While it is low, `disp_vld_o` is 0 at once. It also clears every pending flag, every age counter and every scoreboard busy bit. After release, a warp loaded before the reset never dispatches, and a register marked busy before the reset reads as free.
- R2: A load pulse (`ld_en_i`) writes `ld_instr_i` into the holding register of warp `ld_warp_i` and marks that warp pending. If the warp is eligible, the first dispatch beat appears at the clock edge that follows the loading edge.
- R3: A dispatch lasts WARP_SIZE/LANES consecutive cycles (4 by default) with `disp_vld_o` high. `disp_lgrp_o` counts 0, 1, 2 and 3 in turn. `disp_warp_o` and `disp_instr_o` stay constant for the whole dispatch and equal the instruction held at grant time, even if that warp is reloaded while the dispatch is running.
- R4: If any warp is eligible during the last beat, the next cycle carries lane group 0 of the newly chosen warp, with no idle cycle in between.
- R5: Instruction fields are: first source in bits [REG_W-1:0], second source in bits [2*REG_W-1:REG_W], destination in bits [3*REG_W-1:2*REG_W]. A pending warp is eligible only when none of these three registers is busy in that warp's own scoreboard.
- R6: An issue marks its destination register busy for the issuing warp. A clear pulse (`clr_en_i`, `clr_warp_i`, `clr_reg_i`) frees exactly that warp and register. A clear that names another warp or another register leaves the blocked warp blocked.
- R7: Among eligible warps, the one with the largest age wins, and on equal ages the lowest warp ID wins. A warp's age is reset to 0 when it issues. On every issue by another warp, the age of each pending warp rises by one, saturating.
- R8: When no warp is eligible at a selection point, `disp_vld_o` is 0. The choice is re-evaluated every cycle, so a warp that becomes eligible starts dispatching at the next clock edge.
- R9: A grant clears the warp's pending flag, so each load yields exactly one dispatch, unless that warp is reloaded at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 1 | Load strobe from fetch |
| ld_warp_i | input | WID_W | Warp receiving the instruction |
| ld_instr_i | input | INSTR_W | Next instruction word |
| clr_en_i | input | 1 | Writeback clear strobe |
| clr_warp_i | input | WID_W | Warp of the written register |
| clr_reg_i | input | REG_W | Index of the written register |
| disp_vld_o | output | 1 | Dispatch beat valid |
| disp_warp_o | output | WID_W | Warp being dispatched |
| disp_lgrp_o | output | BEAT_W | Lane group of this beat |
| disp_instr_o | output | INSTR_W | Instruction broadcast to all lanes |

## Verification
A scoreboard bit left set shows up at the ports as a warp that never dispatches again: the strobe stays low in the cycle right after its load or clear. A bit left clear shows up as a dependent warp that dispatches in that very cycle. A lost or stuck pending flag is visible at the next selection point, as a missing or repeated dispatch. A wrong age value changes which warp ID appears at the next lane group 0, which can be at most four cycles after the fault. Faults in the beat counter or the payload registers are visible within a single dispatch, as a skipped group or a payload that changes in mid-dispatch.

// File: rtl/wis_pkg.sv
package wis_pkg;

  localparam int DEF_WARPS     = 24;
  localparam int DEF_WARP_SIZE = 32;
  localparam int DEF_LANES     = 8;
  localparam int DEF_REG_W     = 3;
  localparam int DEF_INSTR_W   = 32;
  localparam int DEF_AGE_W     = 5;

  // index width that never collapses to zero bits
  function automatic int ceil_log2(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
  parameter int NW    = 24,
  parameter int REG_W = 3,
  parameter int WID_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NW-1:0][REG_W-1:0]  src0_i,
  input  logic [NW-1:0][REG_W-1:0]  src1_i,
  input  logic [NW-1:0][REG_W-1:0]  dst_i,
  input  logic                      iss_en_i,
  input  logic [WID_W-1:0]          iss_warp_i,
  input  logic                      clr_en_i,
  input  logic [WID_W-1:0]          clr_warp_i,
  input  logic [REG_W-1:0]          clr_reg_i,
  output logic [NW-1:0]             ready_o
);

  localparam int NREG = 1 << REG_W;
  localparam logic [WID_W:0] NW_C = (WID_W+1)'(NW);

  logic [NW-1:0][NREG-1:0] busy_q, busy_d;
  logic                    clr_ok;
  logic                    upd_en;
  logic [REG_W-1:0]        iss_dst;

  assign clr_ok  = clr_en_i && ({1'b0, clr_warp_i} < NW_C);
  assign upd_en  = clr_ok || iss_en_i;
  assign iss_dst = dst_i[iss_warp_i];

  always_comb begin
    busy_d = busy_q;
    if (clr_ok)   busy_d[clr_warp_i][clr_reg_i] = 1'b0;
    if (iss_en_i) busy_d[iss_warp_i][iss_dst]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= '0;
    else if (upd_en) busy_q <= busy_d;
  end

  for (genvar w = 0; w < NW; w++) begin : g_rdy
    assign ready_o[w] = !busy_q[w][src0_i[w]] &&
                        !busy_q[w][src1_i[w]] &&
                        !busy_q[w][dst_i[w]];
  end

  // R5
  iss_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en_i |-> ready_o[iss_warp_i]);

  // R6
  dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en_i |=> busy_q[$past(iss_warp_i)][$past(iss_dst)]);

  logic clr_same_as_iss;
  assign clr_same_as_iss = iss_en_i && (iss_warp_i == clr_warp_i) && (iss_dst == clr_reg_i);

  // R6
  clr_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !clr_same_as_iss) |=> !busy_q[$past(clr_warp_i)][$past(clr_reg_i)]);

endmodule

// File: rtl/wis_age_arb.sv
module wis_age_arb #(
  parameter int NW    = 24,
  parameter int AGE_W = 5,
  parameter int WID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    pend_i,
  input  logic [NW-1:0]    elig_i,
  input  logic             sel_pt_i,
  output logic             grant_en_o,
  output logic [WID_W-1:0] grant_id_o,
  output logic [NW-1:0]    grant_oh_o
);

  logic [NW-1:0][AGE_W-1:0] age_q, age_d;
  logic                     found;
  logic [AGE_W-1:0]         best_age;
  logic [WID_W-1:0]         best_id;

  // oldest eligible warp; strict compare keeps the lowest ID on ties
  always_comb begin
    found    = 1'b0;
    best_age = '0;
    best_id  = '0;
    for (int i = 0; i < NW; i++) begin
      if (elig_i[i] && (!found || (age_q[i] > best_age))) begin
        found    = 1'b1;
        best_age = age_q[i];
        best_id  = WID_W'(i);
      end
    end
  end

  assign grant_en_o = sel_pt_i && found;
  assign grant_id_o = best_id;

  always_comb begin
    for (int i = 0; i < NW; i++)
      grant_oh_o[i] = grant_en_o && (best_id == WID_W'(i));
  end

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      if (grant_oh_o[i])
        age_d[i] = '0;
      else if (pend_i[i] && (age_q[i] != {AGE_W{1'b1}}))
        age_d[i] = age_q[i] + 1'b1;
      else
        age_d[i] = age_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (grant_en_o) age_q <= age_d;
  end

  // independent scan for a better candidate than the granted one
  logic better_exists;
  always_comb begin
    better_exists = 1'b0;
    for (int i = 0; i < NW; i++) begin
      if (elig_i[i] &&
          ((age_q[i] > age_q[grant_id_o]) ||
           ((age_q[i] == age_q[grant_id_o]) && (WID_W'(i) < grant_id_o))))
        better_exists = 1'b1;
    end
  end

  // R7
  oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en_o |-> (!better_exists && elig_i[grant_id_o]));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh_o));

endmodule

// File: rtl/wis_dispatch.sv
module wis_dispatch #(
  parameter int WID_W   = 5,
  parameter int INSTR_W = 32,
  parameter int BEATS   = 4,
  parameter int BEAT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant_en_i,
  input  logic [WID_W-1:0]   grant_id_i,
  input  logic [INSTR_W-1:0] grant_instr_i,
  output logic               sel_pt_o,
  output logic               vld_o,
  output logic [WID_W-1:0]   warp_o,
  output logic [BEAT_W-1:0]  beat_o,
  output logic [INSTR_W-1:0] instr_o
);

  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic               vld_q, vld_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [WID_W-1:0]   warp_q;
  logic [INSTR_W-1:0] instr_q;
  logic               pay_en;

  assign sel_pt_o = !vld_q || (beat_q == LAST);
  assign pay_en   = sel_pt_o && grant_en_i;

  always_comb begin
    if (sel_pt_o) begin
      vld_d  = grant_en_i;
      beat_d = '0;
    end else begin
      vld_d  = 1'b1;
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      vld_q  <= vld_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pay_en) begin
      warp_q  <= grant_id_i;
      instr_q <= grant_instr_i;
    end
  end

  assign vld_o   = vld_q;
  assign warp_o  = warp_q;
  assign beat_o  = beat_q;
  assign instr_o = instr_q;

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && (beat_q != LAST)) |=> (vld_q && (beat_q == $past(beat_q) + 1'b1)));

  // R3
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && (beat_q != LAST)) |=> ($stable(warp_q) && $stable(instr_q)));

  // R4
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pt_o && grant_en_i) |=> (vld_q && (beat_q == '0) && (warp_q == $past(grant_id_i))));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = DEF_WARPS,
  parameter int WARP_SIZE = DEF_WARP_SIZE,
  parameter int LANES     = DEF_LANES,
  parameter int REG_W     = DEF_REG_W,
  parameter int INSTR_W   = DEF_INSTR_W,
  parameter int AGE_W     = DEF_AGE_W,
  localparam int WID_W    = ceil_log2(NUM_WARPS),
  localparam int BEATS    = WARP_SIZE / LANES,
  localparam int BEAT_W   = ceil_log2(BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en_i,
  input  logic [WID_W-1:0]   ld_warp_i,
  input  logic [INSTR_W-1:0] ld_instr_i,
  input  logic               clr_en_i,
  input  logic [WID_W-1:0]   clr_warp_i,
  input  logic [REG_W-1:0]   clr_reg_i,
  output logic               disp_vld_o,
  output logic [WID_W-1:0]   disp_warp_o,
  output logic [BEAT_W-1:0]  disp_lgrp_o,
  output logic [INSTR_W-1:0] disp_instr_o
);

  localparam logic [WID_W:0] NW_C = (WID_W+1)'(NUM_WARPS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-warp holding registers
  logic [NUM_WARPS-1:0]              pend_q, pend_d;
  logic [NUM_WARPS-1:0][INSTR_W-1:0] ninstr_q;
  logic [NUM_WARPS-1:0]              ld_hit;
  logic [NUM_WARPS-1:0][REG_W-1:0]   f_src0, f_src1, f_dst;
  logic [NUM_WARPS-1:0]              ready, elig, grant_oh;
  logic                              grant_en, sel_pt;
  logic [WID_W-1:0]                  grant_id;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign ld_hit[w] = ld_en_i && (ld_warp_i == WID_W'(w));

    always_ff @(posedge clk) begin
      if (ld_hit[w]) ninstr_q[w] <= ld_instr_i;
    end

    assign f_src0[w] = ninstr_q[w][REG_W-1:0];
    assign f_src1[w] = ninstr_q[w][2*REG_W-1:REG_W];
    assign f_dst[w]  = ninstr_q[w][3*REG_W-1:2*REG_W];
  end

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++)
      pend_d[w] = ld_hit[w] || (pend_q[w] && !grant_oh[w]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pend_q <= '0;
    else            pend_q <= pend_d;
  end

  assign elig = pend_q & ready;

  wis_scoreboard #(
    .NW    (NUM_WARPS),
    .REG_W (REG_W),
    .WID_W (WID_W)
  ) u_sb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .src0_i     (f_src0),
    .src1_i     (f_src1),
    .dst_i      (f_dst),
    .iss_en_i   (grant_en),
    .iss_warp_i (grant_id),
    .clr_en_i   (clr_en_i),
    .clr_warp_i (clr_warp_i),
    .clr_reg_i  (clr_reg_i),
    .ready_o    (ready)
  );

  wis_age_arb #(
    .NW    (NUM_WARPS),
    .AGE_W (AGE_W),
    .WID_W (WID_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pend_i     (pend_q),
    .elig_i     (elig),
    .sel_pt_i   (sel_pt),
    .grant_en_o (grant_en),
    .grant_id_o (grant_id),
    .grant_oh_o (grant_oh)
  );

  wis_dispatch #(
    .WID_W   (WID_W),
    .INSTR_W (INSTR_W),
    .BEATS   (BEATS),
    .BEAT_W  (BEAT_W)
  ) u_disp (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .grant_en_i    (grant_en),
    .grant_id_i    (grant_id),
    .grant_instr_i (ninstr_q[grant_id]),
    .sel_pt_o      (sel_pt),
    .vld_o         (disp_vld_o),
    .warp_o        (disp_warp_o),
    .beat_o        (disp_lgrp_o),
    .instr_o       (disp_instr_o)
  );

  logic ld_ok;
  assign ld_ok = ld_en_i && ({1'b0, ld_warp_i} < NW_C);

  // R2
  load_pending_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_ok |=> pend_q[$past(ld_warp_i)]);

  // R9
  grant_consumes_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (grant_en && !(ld_en_i && (ld_warp_i == grant_id))) |=> !pend_q[$past(grant_id)]);

  // R9
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    grant_en |-> pend_q[grant_id]);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_int_n |-> !disp_vld_o);

endmodule

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;

  localparam int NW = 4;
  localparam int RW = 2;
  localparam int IW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_en;
  logic [1:0]    ld_warp;
  logic [IW-1:0] ld_instr;
  logic          clr_en;
  logic [1:0]    clr_warp;
  logic [RW-1:0] clr_reg;
  logic          vld;
  logic [1:0]    warp;
  logic [1:0]    lgrp;
  logic [IW-1:0] instr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  warp_issue_sched #(
    .NUM_WARPS (NW),
    .WARP_SIZE (32),
    .LANES     (8),
    .REG_W     (RW),
    .INSTR_W   (IW),
    .AGE_W     (3)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_en_i      (ld_en),
    .ld_warp_i    (ld_warp),
    .ld_instr_i   (ld_instr),
    .clr_en_i     (clr_en),
    .clr_warp_i   (clr_warp),
    .clr_reg_i    (clr_reg),
    .disp_vld_o   (vld),
    .disp_warp_o  (warp),
    .disp_lgrp_o  (lgrp),
    .disp_instr_o (instr)
  );

  // layout: op[11:6] dst[5:4] src1[3:2] src0[1:0]
  function automatic logic [IW-1:0] mk(input int op, input int d, input int s1, input int s0);
    return {6'(op), 2'(d), 2'(s1), 2'(s0)};
  endfunction

  task automatic chk_disp(input string req, input logic v, input int w, input int b,
                          input logic [IW-1:0] ins);
    logic ok;
    total++;
    if (!v) ok = (vld == 1'b0);
    else    ok = (vld === 1'b1) && (warp == 2'(w)) && (lgrp == 2'(b)) && (instr == ins);
    if (!ok) begin
      bad++;
      $display("FAIL %s: got vld=%0b warp=%0d grp=%0d instr=%h, expected vld=%0b warp=%0d grp=%0d instr=%h",
               req, vld, warp, lgrp, instr, v, w, b, ins);
    end
  endtask

  task automatic expect_from(input string req, input int w, input logic [IW-1:0] ins, input int b0);
    for (int b = b0; b < 4; b++) begin
      chk_disp(req, 1'b1, w, b, ins);
      @(negedge clk);
    end
  endtask

  task automatic idle_chk(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk_disp(req, 1'b0, 0, 0, '0);
      @(negedge clk);
    end
  endtask

  task automatic drv_ld(input int w, input logic [IW-1:0] ins);
    ld_en = 1'b1; ld_warp = 2'(w); ld_instr = ins;
  endtask

  task automatic drv_idle();
    ld_en = 1'b0; clr_en = 1'b0;
  endtask

  task automatic load_go(input int w, input logic [IW-1:0] ins);
    drv_ld(w, ins);
    @(negedge clk);
    drv_idle();
    @(negedge clk);
  endtask

  task automatic clr_go(input int w, input int r);
    clr_en = 1'b1; clr_warp = 2'(w); clr_reg = 2'(r);
    @(negedge clk);
    drv_idle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got no end of test, expected end within limit");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    ld_en = 0; ld_warp = 0; ld_instr = 0;
    clr_en = 0; clr_warp = 0; clr_reg = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset
    idle_chk("R1", 3);

    // R2 / R3: single dispatch, then idle
    load_go(2, mk(5, 1, 2, 3));
    expect_from("R2", 2, mk(5, 1, 2, 3), 0);
    idle_chk("R8", 1);

    // R5: first source busy (w2 r1)
    load_go(2, mk(6, 0, 0, 1));
    idle_chk("R5", 3);

    // R6: scoreboard is per warp, w1 r1 is free
    load_go(1, mk(7, 3, 1, 1));
    expect_from("R6", 1, mk(7, 3, 1, 1), 0);

    // R6: clears to other warp / other register do nothing
    clr_go(0, 1);
    idle_chk("R6", 2);
    clr_go(2, 2);
    idle_chk("R6", 2);

    // R8: matching clear releases the waiting warp next edge
    clr_go(2, 1);
    expect_from("R8", 2, mk(6, 0, 0, 1), 0);

    // R5: destination busy blocks (w2 r0)
    load_go(2, mk(8, 0, 2, 2));
    idle_chk("R5", 3);
    clr_go(2, 0);
    expect_from("R5", 2, mk(8, 0, 2, 2), 0);

    // R1: reset mid dispatch with a blocked warp pending
    load_go(2, mk(9, 1, 0, 0));
    idle_chk("R5", 1);
    load_go(3, mk(3, 2, 1, 1));
    chk_disp("R2", 1'b1, 3, 0, mk(3, 2, 1, 1));
    rst_n = 1'b0;
    #1;
    chk_disp("R1", 1'b0, 0, 0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_chk("R1", 3);
    load_go(2, mk(4, 1, 0, 0));
    expect_from("R1", 2, mk(4, 1, 0, 0), 0);
    clr_en = 1'b1; clr_warp = 2'd2; clr_reg = 2'd1;
    @(negedge clk);
    drv_idle();
    @(negedge clk);

    // sweep every warp and register: second source dependency
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < 4; r++) begin
        int nr;
        nr = (r + 1) % 4;
        load_go(w, mk(16 + w*4 + r, r, r, r));
        expect_from("R3", w, mk(16 + w*4 + r, r, r, r), 0);
        load_go(w, mk(32 + w*4 + r, nr, r, nr));
        idle_chk("R5", 2);
        clr_go(w, r);
        expect_from("R6", w, mk(32 + w*4 + r, nr, r, nr), 0);
        clr_en = 1'b1; clr_warp = 2'(w); clr_reg = 2'(nr);
        @(negedge clk);
        drv_idle();
        @(negedge clk);
      end
    end

    // R7 / R4: ages decide order, no gaps between warps
    drv_ld(3, mk(10, 0, 1, 1));
    @(negedge clk);
    drv_ld(0, mk(11, 0, 1, 1));
    @(negedge clk);
    chk_disp("R2", 1'b1, 3, 0, mk(10, 0, 1, 1));
    drv_ld(1, mk(12, 0, 1, 1));
    @(negedge clk);
    chk_disp("R3", 1'b1, 3, 1, mk(10, 0, 1, 1));
    drv_ld(2, mk(13, 0, 1, 1));
    @(negedge clk);
    chk_disp("R3", 1'b1, 3, 2, mk(10, 0, 1, 1));
    drv_ld(3, mk(14, 2, 3, 3));
    @(negedge clk);
    chk_disp("R3", 1'b1, 3, 3, mk(10, 0, 1, 1));
    drv_idle();
    @(negedge clk);
    chk_disp("R4", 1'b1, 0, 0, mk(11, 0, 1, 1));
    drv_ld(0, mk(15, 2, 3, 3));
    @(negedge clk);
    chk_disp("R3", 1'b1, 0, 1, mk(11, 0, 1, 1));
    drv_idle();
    @(negedge clk);
    expect_from("R3", 0, mk(11, 0, 1, 1), 2);
    expect_from("R7", 1, mk(12, 0, 1, 1), 0);
    expect_from("R7", 2, mk(13, 0, 1, 1), 0);
    expect_from("R7", 3, mk(14, 2, 3, 3), 0);
    expect_from("R7", 0, mk(15, 2, 3, 3), 0);
    // R9: each load dispatched once
    idle_chk("R9", 3);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule